// File: doc/BRIEF.md
# Debug Port Wire-Mode Selector

This block decides whether a two-wire-capable debug port talks JTAG or serial-wire protocol. It samples the shared mode-select/data line on each rising edge of the shared debug clock. The port starts in JTAG mode after power-on reset. It moves to serial-wire mode only after it sees three phases in order: a long run of ones on the line, a fixed 16-bit selection key, and a second long run of ones.

The change of mode is sticky. Only power-on reset clears it; system reset is not an input of this block. When the mode changes, the block raises a single-cycle switch pulse. It also raises a control that holds the boundary-scan TAP's mode-select input high, which parks that TAP while the port is in serial-wire mode. The TAP controller and the serial-wire protocol engine sit outside this block and take the mode flag.

The minimum run length, the counter ceiling, the key and its bit order are all parameters. The run counter saturates, so an idle line held high for a long time never wraps it.

Top module: `dbg_wire_mode_sel`

## Requirements
- R1: While `por_n_i` is low, and at the first sample after it is released, `swd_mode_o`, `switch_pulse_o` and `bscan_tms_hold_o` are all 0 (JTAG mode).
- R2: The key phase is entered only when a 0 is sampled after more than RUN_MIN (default 50) consecutive 1 samples. A run of exactly 50 ones followed by the key never leads to serial-wire mode.
- R3: The key is 16'h79E7 received most significant bit first (0,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1). Its first bit (0) is the sample that ends the lead run. Any bit that differs from this key abandons the sequence, and the same key sent in reversed bit order does not switch the mode.
- R4: Serial-wire mode is committed only after more than 50 consecutive 1 samples that follow the last key bit. A trailing run of exactly 50 ones followed by a 0 does not commit, and the sequence must then start again from the lead run.
- R5: On the clock edge that samples the 51st trailing 1, `swd_mode_o` and `bscan_tms_hold_o` go to 1. From then on both stay at 1 whatever the line does, until `por_n_i` is asserted.
- R6: `switch_pulse_o` is high for exactly one clock per mode change, in the same cycle in which `swd_mode_o` first reads 1, and is 0 in all other cycles.
- R7: The run counter saturates at RUN_SAT (default 64). A lead run of 200 ones followed by the key and 51 ones still switches the mode on the 51st trailing one.
- R8: When a key bit mismatches on a sampled 1, that 1 counts as the first 1 of a new lead run. After such a mismatch, 50 further ones (51 in total), then the key, then 51 ones switch the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared debug clock; the line is sampled on its rising edge |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| sel_i | input | 1 | Shared mode-select/data line |
| swd_mode_o | output | 1 | 1 = serial-wire mode, 0 = JTAG mode |
| switch_pulse_o | output | 1 | One-cycle pulse when the mode changes to serial-wire |
| bscan_tms_hold_o | output | 1 | Holds the boundary-scan TAP's mode-select input high |

## Verification
Every output is a register, so the effect of a line sample appears right after the rising edge that takes it. The mode flag, the hold control and the pulse all change at the edge that samples the 51st trailing one. The bench changes `sel_i` 2 ns after each rising edge and reads the outputs at the same point, after the edge that sampled the bit. It reads the mode one bit before and one bit after the commit edge, which pins the switch to the exact sample. A running count of pulse cycles shows that no pulse appears in the scenarios that must not switch, and that exactly one appears when the mode changes.

// File: rtl/dbg_sel_pkg.sv
package dbg_sel_pkg;

   typedef enum logic [1:0] {
      PH_LEAD  = 2'd0,   // counting leading ones
      PH_KEY   = 2'd1,   // matching the selection key
      PH_TRAIL = 2'd2,   // counting trailing ones
      PH_SWD   = 2'd3    // serial-wire mode committed (sticky)
   } phase_e;

endpackage

// File: rtl/dbg_run_counter.sv
module dbg_run_counter #(
   parameter int RUN_SAT = 64
) (
   input  logic                          clk_i,
   input  logic                          por_n_i,
   input  logic                          inc_i,
   input  logic                          clr_i,
   input  logic                          seed_i,
   output logic [$clog2(RUN_SAT+1)-1:0]  cnt_o
);
   localparam int CW = $clog2(RUN_SAT+1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= {{(CW-1){1'b0}}, seed_i};
      else if (inc_i && (cnt_q != CW'(RUN_SAT)))
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R7: the count never passes the saturation ceiling
   assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
      cnt_q <= CW'(RUN_SAT));

   // R7: at the ceiling a further increment leaves the count unchanged
   assert_sat_hold_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (inc_i && !clr_i && cnt_q == CW'(RUN_SAT)) |=> (cnt_q == CW'(RUN_SAT)));
endmodule

// File: rtl/dbg_key_tracker.sv
module dbg_key_tracker #(
   parameter int              KEY_W     = 16,
   parameter logic [KEY_W-1:0] KEY      = 16'h79E7,
   parameter bit              MSB_FIRST = 1'b1
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic start_i,
   input  logic adv_i,
   output logic first_bit_o,
   output logic exp_bit_o,
   output logic last_o
);
   localparam int IW = (KEY_W > 2) ? $clog2(KEY_W) : 1;

   logic [KEY_W-1:0] key_ord;
   logic [IW-1:0]    idx_q;

   // key reordered so that position 0 is the first bit on the wire
   generate
      if (MSB_FIRST) begin : g_msb
         for (genvar i = 0; i < KEY_W; i++) begin : g_bit
            assign key_ord[i] = KEY[KEY_W-1-i];
         end
      end else begin : g_lsb
         assign key_ord = KEY;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)
         idx_q <= '0;
      else if (start_i)
         idx_q <= IW'(1);
      else if (adv_i)
         idx_q <= idx_q + 1'b1;
   end

   assign first_bit_o = key_ord[0];
   assign exp_bit_o   = key_ord[idx_q];
   assign last_o      = (idx_q == IW'(KEY_W-1));

   // R3: the sequencer never advances past the final key bit
   assert_idx_bound_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      adv_i |-> !last_o);
endmodule

// File: rtl/dbg_mode_out.sv
module dbg_mode_out (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic commit_i,
   output logic swd_mode_o,
   output logic pulse_o,
   output logic tms_hold_o
);
   logic mode_q;
   logic pulse_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         mode_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         mode_q  <= mode_q | commit_i;
         pulse_q <= commit_i & ~mode_q;
      end
   end

   assign swd_mode_o = mode_q;
   assign pulse_o    = pulse_q;
   assign tms_hold_o = mode_q;

   // R5: serial-wire mode is sticky until power-on reset
   assert_mode_sticky_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      mode_q |=> mode_q);

   // R6: pulse lasts one cycle
   assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      pulse_q |=> !pulse_q);

   // R6: pulse only on the rising of the mode
   assert_pulse_edge_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      pulse_q |-> (mode_q && !$past(mode_q)));
endmodule

// File: rtl/dbg_wire_mode_sel.sv
module dbg_wire_mode_sel #(
   parameter int               RUN_MIN   = 50,
   parameter int               RUN_SAT   = 64,
   parameter int               KEY_W     = 16,
   parameter logic [KEY_W-1:0] KEY       = 16'h79E7,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic sel_i,
   output logic swd_mode_o,
   output logic switch_pulse_o,
   output logic bscan_tms_hold_o
);
   import dbg_sel_pkg::*;

   localparam int CW = $clog2(RUN_SAT+1);
   localparam logic FIRST_KEY_BIT = MSB_FIRST ? KEY[KEY_W-1] : KEY[0];

   // elaboration-time parameter checks
   generate
      if (RUN_SAT <= RUN_MIN) begin : g_bad_sat
         $error("RUN_SAT must exceed RUN_MIN");
      end
      if (KEY_W < 2) begin : g_bad_w
         $error("KEY_W must be at least 2");
      end
      if (FIRST_KEY_BIT != 1'b0) begin : g_bad_key
         $error("first key bit on the wire must be 0 to end the lead run");
      end
   endgenerate

   phase_e        ph_q, ph_d;
   logic [CW-1:0] cnt;
   logic          cnt_inc, cnt_clr, cnt_seed;
   logic          key_start, key_adv;
   logic          key_first, key_exp, key_last;
   logic          commit;
   logic          run_done;

   assign run_done = (cnt >= CW'(RUN_MIN));   // with this 1, run exceeds RUN_MIN

   dbg_run_counter #(.RUN_SAT(RUN_SAT)) u_run (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .inc_i   (cnt_inc),
      .clr_i   (cnt_clr),
      .seed_i  (cnt_seed),
      .cnt_o   (cnt)
   );

   dbg_key_tracker #(.KEY_W(KEY_W), .KEY(KEY), .MSB_FIRST(MSB_FIRST)) u_key (
      .clk_i       (clk_i),
      .por_n_i     (por_n_i),
      .start_i     (key_start),
      .adv_i       (key_adv),
      .first_bit_o (key_first),
      .exp_bit_o   (key_exp),
      .last_o      (key_last)
   );

   dbg_mode_out u_out (
      .clk_i      (clk_i),
      .por_n_i    (por_n_i),
      .commit_i   (commit),
      .swd_mode_o (swd_mode_o),
      .pulse_o    (switch_pulse_o),
      .tms_hold_o (bscan_tms_hold_o)
   );

   always_comb begin
      ph_d      = ph_q;
      cnt_inc   = 1'b0;
      cnt_clr   = 1'b0;
      cnt_seed  = 1'b0;
      key_start = 1'b0;
      key_adv   = 1'b0;
      commit    = 1'b0;
      unique case (ph_q)
         PH_LEAD: begin
            if (sel_i) begin
               cnt_inc = 1'b1;
            end else begin
               cnt_clr = 1'b1;
               if (cnt > CW'(RUN_MIN) && sel_i == key_first) begin
                  key_start = 1'b1;
                  ph_d      = PH_KEY;
               end
            end
         end
         PH_KEY: begin
            if (sel_i == key_exp) begin
               if (key_last) begin
                  cnt_clr = 1'b1;
                  ph_d    = PH_TRAIL;
               end else begin
                  key_adv = 1'b1;
               end
            end else begin
               cnt_clr  = 1'b1;
               cnt_seed = sel_i;        // mismatching 1 opens a new lead run
               ph_d     = PH_LEAD;
            end
         end
         PH_TRAIL: begin
            if (sel_i) begin
               cnt_inc = 1'b1;
               if (run_done) begin
                  commit = 1'b1;
                  ph_d   = PH_SWD;
               end
            end else begin
               cnt_clr = 1'b1;
               ph_d    = PH_LEAD;
            end
         end
         PH_SWD: begin
            ph_d = PH_SWD;
         end
         default: ph_d = PH_LEAD;
      endcase
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)
         ph_q <= PH_LEAD;
      else
         ph_q <= ph_d;
   end

   // R2: key phase is entered only after a long enough lead run
   assert_key_entry_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ph_q == PH_LEAD && ph_d == PH_KEY) |-> (cnt > CW'(RUN_MIN) && !sel_i));

   // R4: commit happens only out of the trailing phase on a sampled 1
   assert_commit_src_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(swd_mode_o) |-> ($past(ph_q) == PH_TRAIL && $past(sel_i)));

   // R5: the sequencer phase and the output mode agree
   assert_mode_match_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ph_q == PH_SWD) == swd_mode_o);
endmodule

// File: tb/dbg_wire_mode_sel_bench.sv
`timescale 1ns/1ps
module dbg_wire_mode_sel_bench;
   localparam logic [15:0] KEY = 16'h79E7;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sel = 1'b1;
   logic swd_mode, pulse, tms_hold;

   int n_checks = 0;
   int n_fail   = 0;
   int pulse_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dbg_wire_mode_sel u_dbg_wire_mode_sel (
      .clk_i            (clk),
      .por_n_i          (por_n),
      .sel_i            (sel),
      .swd_mode_o       (swd_mode),
      .switch_pulse_o   (pulse),
      .bscan_tms_hold_o (tms_hold)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive one bit, let the rising edge take it, then settle
   task automatic bit_in(input logic b);
      sel = b;
      @(posedge clk);
      #2;
      if (pulse === 1'b1) pulse_cnt++;
   endtask

   task automatic ones(input int n);
      for (int i = 0; i < n; i++) bit_in(1'b1);
   endtask

   task automatic word_msb(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) bit_in(w[i]);
   endtask

   task automatic do_por();
      por_n = 1'b0;
      sel = 1'b1;
      @(posedge clk);
      #2;
      por_n = 1'b1;
      pulse_cnt = 0;
   endtask

   task automatic t_reset();
      por_n = 1'b0;
      @(posedge clk);
      #2;
      check("R1 mode in reset", swd_mode, 1'b0);
      check("R1 pulse in reset", pulse, 1'b0);
      check("R1 hold in reset", tms_hold, 1'b0);
      por_n = 1'b1;
      bit_in(1'b1);
      check("R1 mode after release", swd_mode, 1'b0);
      pulse_cnt = 0;
   endtask

   task automatic t_full_switch();
      do_por();
      ones(51);
      word_msb(KEY);
      ones(50);
      check("R4 no commit after 50 trailing ones", swd_mode, 1'b0);
      check("R6 no pulse yet", pulse, 1'b0);
      bit_in(1'b1);
      check("R5 mode on 51st trailing one", swd_mode, 1'b1);
      check("R5 hold on 51st trailing one", tms_hold, 1'b1);
      check("R6 pulse with mode", pulse, 1'b1);
      bit_in(1'b1);
      check("R6 pulse one cycle", pulse, 1'b0);
      for (int i = 0; i < 20; i++) bit_in(1'b0);
      word_msb(KEY);
      ones(60);
      check("R5 mode sticky", swd_mode, 1'b1);
      check("R5 hold sticky", tms_hold, 1'b1);
      check_int("R6 exactly one pulse", pulse_cnt, 1);
      por_n = 1'b0;
      #3;
      check("R1 POR clears mode", swd_mode, 1'b0);
      por_n = 1'b1;
   endtask

   task automatic t_short_lead();
      do_por();
      bit_in(1'b0);
      ones(50);
      word_msb(KEY);
      ones(60);
      check("R2 50 lead ones do not open key", swd_mode, 1'b0);
      check_int("R2 no pulse", pulse_cnt, 0);
   endtask

   task automatic t_short_trail();
      do_por();
      ones(51);
      word_msb(KEY);
      ones(50);
      bit_in(1'b0);
      ones(60);
      check("R4 50 trailing ones then 0 abort", swd_mode, 1'b0);
      check_int("R4 no pulse", pulse_cnt, 0);
   endtask

   task automatic t_bad_key();
      do_por();
      ones(51);
      word_msb(KEY ^ 16'h0040);   // flip the tenth bit sent
      ones(60);
      check("R3 flipped key bit rejected", swd_mode, 1'b0);
      do_por();
      ones(51);
      word_msb({<<{KEY}});        // reversed bit order
      ones(60);
      check("R3 reversed key rejected", swd_mode, 1'b0);
      check_int("R3 no pulse", pulse_cnt, 0);
   endtask

   task automatic t_restart();
      do_por();
      ones(51);
      bit_in(1'b0); bit_in(1'b1); bit_in(1'b1); bit_in(1'b1); bit_in(1'b1);
      bit_in(1'b1);               // key expects 0 here: mismatch on a 1
      ones(50);                   // 51 ones including the mismatching bit
      word_msb(KEY);
      ones(50);
      check("R8 not before 51st trailing one", swd_mode, 1'b0);
      bit_in(1'b1);
      check("R8 mismatching 1 starts new run", swd_mode, 1'b1);
   endtask

   task automatic t_long_lead();
      do_por();
      ones(200);
      word_msb(KEY);
      ones(50);
      check("R7 not before 51st trailing one", swd_mode, 1'b0);
      bit_in(1'b1);
      check("R7 saturated lead run still valid", swd_mode, 1'b1);
      check("R7 pulse", pulse, 1'b1);
   endtask

   initial begin
      t_reset();
      t_full_switch();
      t_short_lead();
      t_short_trail();
      t_bad_key();
      t_restart();
      t_long_lead();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule